// File: doc/BRIEF.md
# Interrupt and Reset Arbitration Controller

This block decides, at each instruction boundary of an 8-bit CPU core, whether the core fetches the next opcode as usual or enters a service sequence: a reset, a non-maskable interrupt, or a maskable interrupt in one of three modes. It owns the two interrupt enable flip-flops (the live enable and its saved copy), the interrupt mode register and the halt state. The core drives it with strobes marking the end of each bus machine cycle and each instruction boundary, and with one-cycle decoded pulses for the enable, disable, return-from-NMI, halt and mode-select instructions.

The requests are collected continuously. The reset request is a level. The non-maskable request is latched on a rising edge of its line. The maskable request counts only while its line is high and the live enable is set. These requests are copied into a sample register at every machine-cycle-end strobe. At an instruction boundary the sampled requests are arbitrated, and one cycle later the controller presents a one-cycle action pulse with an action code and a restart vector. The same edge updates the enable flags, the mode and the halt state as that action requires. The acknowledge bus cycle, the mode 2 table read and the stack push belong to the core.

Top module: `cpu_intr_ctrl`

## Requirements
- R1: After the synchronous block reset (rst_n low at a clock edge), both enable flags are 0, the mode is 0, halted is 0 and act_valid is 0.
- R2: A request is seen at an instruction boundary only if it was present at a machine-cycle-end strobe that came before that boundary. A boundary strobe in cycle n yields act_valid high in cycle n+1, together with act_code and act_vec.
- R3: Action codes are 0 fetch, 1 reset, 2 NMI, 3 IRQ mode 0, 4 IRQ mode 1, 5 IRQ mode 2. Priority among sampled requests is reset, then NMI, then IRQ. With no request sampled, the action is fetch.
- R4: The NMI request is set only by a 0-to-1 transition of nmi_line and is cleared when the NMI is taken. A line held high does not raise a second request.
- R5: A maskable request is sampled only while irq_line is high and IFF1 is 1. If the line is low at the next machine-cycle-end strobe, no interrupt is taken.
- R6: An enable pulse sets both flags to 1. A disable pulse clears both flags and cancels a sampled maskable request.
- R7: Taking an NMI copies IFF1 into IFF2, clears IFF1, and gives vector 0x0066.
- R8: Taking a maskable interrupt clears both flags. The vector is 0x0038 in modes 0 and 1 and 0x0000 in mode 2. pc_hold is high during a mode 0 action pulse.
- R9: A return-from-NMI pulse copies IFF2 into IFF1. If irq_line is high, the maskable request is taken at the next boundary that follows a machine-cycle-end strobe.
- R10: A mode-select pulse with im_sel 00 or 01 gives mode 0, im_sel 10 gives mode 1, and im_sel 11 gives mode 2.
- R11: A reset action clears both flags, sets mode 0 and gives vector 0x0000. While reset_req stays high, every boundary issues a reset action.
- R12: halted rises on a halt pulse and stays high, with pc_hold, until a non-fetch action is issued. Fetch actions leave it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| reset_req | input | 1 | Level reset request from the system |
| nmi_line | input | 1 | Non-maskable request line, acts on its rising edge |
| irq_line | input | 1 | Maskable request line, level |
| mcycle_end | input | 1 | Strobe at the end of each bus machine cycle |
| instr_boundary | input | 1 | Strobe at each instruction boundary |
| op_ei | input | 1 | Enable-interrupts instruction pulse |
| op_di | input | 1 | Disable-interrupts instruction pulse |
| op_retn | input | 1 | Return-from-NMI instruction pulse |
| op_halt | input | 1 | Halt instruction pulse |
| op_im | input | 1 | Mode-select instruction pulse |
| im_sel | input | 2 | Opcode bits 4:3 of the mode-select instruction |
| act_valid | output | 1 | One-cycle pulse carrying the boundary decision |
| act_code | output | 3 | Chosen action, encoded per R3 |
| act_vec | output | 16 | Restart vector for the chosen action |
| iff1 | output | 1 | Live interrupt enable flag |
| iff2 | output | 1 | Saved interrupt enable flag |
| int_mode | output | 2 | Current maskable interrupt mode |
| halted | output | 1 | Core is in the halt state |
| pc_hold | output | 1 | Program counter must not advance |

## Verification
The assertions assume that at most one of the instruction boundary strobe and the five decoded instruction pulses is high in any cycle, since they come from distinct execution stages of the core. The stimulus drives each of these as a separate single-cycle pulse, and it places machine-cycle-end strobes in their own cycles. The priority sweep covers all eight combinations of the three request sources, and the mode sweep covers all four select codes, each with its own vector and flag results.

// File: rtl/cpu_intr_pkg.sv
// Shared types for the interrupt controller: the service action encoding.
package cpu_intr_pkg;
    typedef enum logic [2:0] {
        ACT_FETCH = 3'd0,
        ACT_RESET = 3'd1,
        ACT_NMI   = 3'd2,
        ACT_IRQ0  = 3'd3,
        ACT_IRQ1  = 3'd4,
        ACT_IRQ2  = 3'd5
    } act_e;

    localparam int ACT_W  = 3;
    localparam int MODE_W = 2;
endpackage

// File: rtl/intr_req_track.sv
// Request tracker: detects NMI rising edges, forms the masked IRQ level and
// samples all three requests at each machine-cycle-end strobe.
// Assumes: take_nmi and drop_irq are single-cycle pulses from the arbiter.
module intr_req_track (
    input  logic clk,
    input  logic rst_n,
    input  logic reset_req,
    input  logic nmi_line,
    input  logic irq_line,
    input  logic iff1,
    input  logic mcycle_end,
    input  logic take_nmi,
    input  logic drop_irq,
    output logic smp_rst,
    output logic smp_nmi,
    output logic smp_irq
);
    logic nmi_q;
    logic nmi_pend;
    logic nmi_edge;

    assign nmi_edge = nmi_line & ~nmi_q;

    // Edge-latched NMI request and the per-machine-cycle request sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nmi_q    <= 1'b0;
            nmi_pend <= 1'b0;
            smp_rst  <= 1'b0;
            smp_nmi  <= 1'b0;
            smp_irq  <= 1'b0;
        end else begin
            nmi_q    <= nmi_line;
            nmi_pend <= nmi_edge | (nmi_pend & ~take_nmi);
            if (mcycle_end)
                smp_rst <= reset_req;
            if (take_nmi)
                smp_nmi <= 1'b0;
            else if (mcycle_end)
                smp_nmi <= nmi_pend;
            if (drop_irq)
                smp_irq <= 1'b0;
            else if (mcycle_end)
                smp_irq <= irq_line & iff1;
        end
    end

    // R4: a fresh NMI request only follows a high line
    assert_nmi_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nmi_pend) |-> $past(nmi_line));

    // R5: a sampled maskable request needs the line and the enable together
    assert_irq_masked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(smp_irq) |-> $past(irq_line && iff1 && mcycle_end));
endmodule

// File: rtl/intr_flag_ctrl.sv
// Enable flags and interrupt mode. Service actions at a boundary take
// precedence; otherwise the decoded instruction pulses update the state.
// Assumes: at most one instruction pulse per cycle.
module intr_flag_ctrl
    import cpu_intr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              svc_fire,
    input  logic [ACT_W-1:0]  svc_act,
    input  logic              op_ei,
    input  logic              op_di,
    input  logic              op_retn,
    input  logic              op_im,
    input  logic [1:0]        im_sel,
    output logic              iff1,
    output logic              iff2,
    output logic [MODE_W-1:0] mode
);
    logic [MODE_W-1:0] im_mode;

    // Maps opcode bits 4:3 onto the mode number.
    always_comb begin
        case (im_sel)
            2'b10:   im_mode = MODE_W'(1);
            2'b11:   im_mode = MODE_W'(2);
            default: im_mode = MODE_W'(0);
        endcase
    end

    // Updates the flag pair and the mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iff1 <= 1'b0;
            iff2 <= 1'b0;
            mode <= '0;
        end else if (svc_fire && act_e'(svc_act) != ACT_FETCH) begin
            case (act_e'(svc_act))
                ACT_RESET: begin
                    iff1 <= 1'b0;
                    iff2 <= 1'b0;
                    mode <= '0;
                end
                ACT_NMI: begin
                    iff2 <= iff1;
                    iff1 <= 1'b0;
                end
                default: begin
                    iff1 <= 1'b0;
                    iff2 <= 1'b0;
                end
            endcase
        end else if (op_ei) begin
            iff1 <= 1'b1;
            iff2 <= 1'b1;
        end else if (op_di) begin
            iff1 <= 1'b0;
            iff2 <= 1'b0;
        end else if (op_retn) begin
            iff1 <= iff2;
        end else if (op_im) begin
            mode <= im_mode;
        end
    end

    // R7: accepting an NMI saves the live enable and clears it
    assert_nmi_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_fire && svc_act == ACT_NMI) |=> (!iff1 && iff2 == $past(iff1)));

    // R9: return-from-NMI restores the live enable from the saved copy
    assert_retn_restore_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_retn && !svc_fire) |=> (iff1 == $past(iff2)));
endmodule

// File: rtl/intr_arbiter.sv
// Boundary arbiter: ranks the sampled requests, issues the action pulse with
// its vector, and keeps the halt state.
// Assumes: instr_boundary and op_halt never fall in the same cycle.
module intr_arbiter
    import cpu_intr_pkg::*;
#(
    parameter int                 ADDR_W    = 16,
    parameter logic [ADDR_W-1:0]  RST_VEC   = 16'h0000,
    parameter logic [ADDR_W-1:0]  NMI_VEC   = 16'h0066,
    parameter logic [ADDR_W-1:0]  IRQ_VEC   = 16'h0038,
    parameter logic [ADDR_W-1:0]  MODE2_VEC = 16'h0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_boundary,
    input  logic              smp_rst,
    input  logic              smp_nmi,
    input  logic              smp_irq,
    input  logic [MODE_W-1:0] mode,
    input  logic              op_halt,
    output logic [ACT_W-1:0]  dec_act,
    output logic              act_valid,
    output logic [ACT_W-1:0]  act_code,
    output logic [ADDR_W-1:0] act_vec,
    output logic              halted,
    output logic              pc_hold
);
    act_e              dec;
    logic [ADDR_W-1:0] dec_vec;

    // Fixed priority over the sampled requests.
    always_comb begin
        if (smp_rst)
            dec = ACT_RESET;
        else if (smp_nmi)
            dec = ACT_NMI;
        else if (smp_irq)
            dec = (mode == MODE_W'(2)) ? ACT_IRQ2 :
                  (mode == MODE_W'(1)) ? ACT_IRQ1 : ACT_IRQ0;
        else
            dec = ACT_FETCH;
    end

    // Restart vector of the chosen action.
    always_comb begin
        case (dec)
            ACT_NMI:  dec_vec = NMI_VEC;
            ACT_IRQ0: dec_vec = IRQ_VEC;
            ACT_IRQ1: dec_vec = IRQ_VEC;
            ACT_IRQ2: dec_vec = MODE2_VEC;
            default:  dec_vec = RST_VEC;
        endcase
    end

    assign dec_act = dec;

    // Registers the decision and tracks the halt state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_valid <= 1'b0;
            act_code  <= ACT_FETCH;
            act_vec   <= '0;
            halted    <= 1'b0;
        end else begin
            act_valid <= instr_boundary;
            if (instr_boundary) begin
                act_code <= dec;
                act_vec  <= dec_vec;
            end
            if (instr_boundary && dec != ACT_FETCH)
                halted <= 1'b0;
            else if (op_halt)
                halted <= 1'b1;
        end
    end

    assign pc_hold = halted | (act_valid && act_code == ACT_IRQ0);

    // R3: a sampled reset always wins the boundary
    assert_reset_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_boundary && smp_rst) |=> (act_valid && act_code == ACT_RESET));

    // R12: halt is released only by a service action
    assert_halt_release_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(halted) |-> (act_valid && act_code != ACT_FETCH));
endmodule

// File: rtl/cpu_intr_ctrl.sv
// Top level of the interrupt and reset controller: request tracking, flag
// and mode state, and boundary arbitration.
// Assumes: the boundary strobe and the instruction pulses are mutually exclusive.
module cpu_intr_ctrl
    import cpu_intr_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reset_req,
    input  logic              nmi_line,
    input  logic              irq_line,
    input  logic              mcycle_end,
    input  logic              instr_boundary,
    input  logic              op_ei,
    input  logic              op_di,
    input  logic              op_retn,
    input  logic              op_halt,
    input  logic              op_im,
    input  logic [1:0]        im_sel,
    output logic              act_valid,
    output logic [2:0]        act_code,
    output logic [ADDR_W-1:0] act_vec,
    output logic              iff1,
    output logic              iff2,
    output logic [1:0]        int_mode,
    output logic              halted,
    output logic              pc_hold
);
    logic             smp_rst;
    logic             smp_nmi;
    logic             smp_irq;
    logic [ACT_W-1:0] dec_act;
    logic             take_nmi;
    logic             drop_irq;

    assign take_nmi = instr_boundary && dec_act == ACT_NMI;
    assign drop_irq = op_di || (instr_boundary && dec_act != ACT_FETCH);

    intr_req_track u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .reset_req  (reset_req),
        .nmi_line   (nmi_line),
        .irq_line   (irq_line),
        .iff1       (iff1),
        .mcycle_end (mcycle_end),
        .take_nmi   (take_nmi),
        .drop_irq   (drop_irq),
        .smp_rst    (smp_rst),
        .smp_nmi    (smp_nmi),
        .smp_irq    (smp_irq)
    );

    intr_flag_ctrl u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .svc_fire (instr_boundary),
        .svc_act  (dec_act),
        .op_ei    (op_ei),
        .op_di    (op_di),
        .op_retn  (op_retn),
        .op_im    (op_im),
        .im_sel   (im_sel),
        .iff1     (iff1),
        .iff2     (iff2),
        .mode     (int_mode)
    );

    intr_arbiter #(.ADDR_W(ADDR_W)) u_arb (
        .clk            (clk),
        .rst_n          (rst_n),
        .instr_boundary (instr_boundary),
        .smp_rst        (smp_rst),
        .smp_nmi        (smp_nmi),
        .smp_irq        (smp_irq),
        .mode           (int_mode),
        .op_halt        (op_halt),
        .dec_act        (dec_act),
        .act_valid      (act_valid),
        .act_code       (act_code),
        .act_vec        (act_vec),
        .halted         (halted),
        .pc_hold        (pc_hold)
    );

    // Input contract: one control event per cycle
    assert_one_event_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({instr_boundary, op_ei, op_di, op_retn, op_halt, op_im}));

    // R6: after a disable pulse both flags read 0
    assert_di_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        op_di |=> (!iff1 && !iff2));
endmodule

// File: tb/cpu_intr_ctrl_bench.sv
module cpu_intr_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reset_req = 1'b0;
    logic        nmi_line = 1'b0;
    logic        irq_line = 1'b0;
    logic        mcycle_end = 1'b0;
    logic        instr_boundary = 1'b0;
    logic        op_ei = 1'b0;
    logic        op_di = 1'b0;
    logic        op_retn = 1'b0;
    logic        op_halt = 1'b0;
    logic        op_im = 1'b0;
    logic [1:0]  im_sel = 2'b00;
    logic        act_valid;
    logic [2:0]  act_code;
    logic [15:0] act_vec;
    logic        iff1;
    logic        iff2;
    logic [1:0]  int_mode;
    logic        halted;
    logic        pc_hold;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    cpu_intr_ctrl u_cpu_intr_ctrl (
        .clk(clk), .rst_n(rst_n), .reset_req(reset_req), .nmi_line(nmi_line),
        .irq_line(irq_line), .mcycle_end(mcycle_end), .instr_boundary(instr_boundary),
        .op_ei(op_ei), .op_di(op_di), .op_retn(op_retn), .op_halt(op_halt),
        .op_im(op_im), .im_sel(im_sel), .act_valid(act_valid), .act_code(act_code),
        .act_vec(act_vec), .iff1(iff1), .iff2(iff2), .int_mode(int_mode),
        .halted(halted), .pc_hold(pc_hold)
    );

    task automatic chk(input string tag, input int actual, input int expected);
        n_chk++;
        if (actual != expected) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, actual, expected);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic block_reset();
        tick();
        rst_n = 1'b0;
        tick();
        tick();
        rst_n = 1'b1;
    endtask

    task automatic mend();
        tick(); mcycle_end = 1'b1;
        tick(); mcycle_end = 1'b0;
    endtask

    task automatic bound();
        tick(); instr_boundary = 1'b1;
        tick(); instr_boundary = 1'b0;
    endtask

    task automatic do_ei();   tick(); op_ei = 1'b1;   tick(); op_ei = 1'b0;   endtask
    task automatic do_di();   tick(); op_di = 1'b1;   tick(); op_di = 1'b0;   endtask
    task automatic do_retn(); tick(); op_retn = 1'b1; tick(); op_retn = 1'b0; endtask
    task automatic do_halt(); tick(); op_halt = 1'b1; tick(); op_halt = 1'b0; endtask

    task automatic do_im(input logic [1:0] s);
        tick(); im_sel = s; op_im = 1'b1;
        tick(); op_im = 1'b0;
    endtask

    task automatic chk_act(input string tag, input int code, input int vec);
        chk({tag, " valid"}, int'(act_valid), 1);
        chk({tag, " code"}, int'(act_code), code);
        chk({tag, " vector"}, int'(act_vec), vec);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        block_reset();
        tick();
        // R1: reset state
        chk("R1 iff1", int'(iff1), 0);
        chk("R1 iff2", int'(iff2), 0);
        chk("R1 mode", int'(int_mode), 0);
        chk("R1 halted", int'(halted), 0);
        chk("R1 act_valid", int'(act_valid), 0);

        // R3 / R7 / R11: all combinations of reset, NMI and IRQ
        for (int k = 0; k < 8; k++) begin
            int exp_code, exp_vec, e1, e2, em;
            block_reset();
            do_ei();
            do_im(2'b10);
            reset_req = k[2];
            nmi_line  = k[1];
            irq_line  = k[0];
            tick();
            mend();
            bound();
            if (k[2]) begin exp_code = 1; exp_vec = 16'h0000; e1 = 0; e2 = 0; em = 0; end
            else if (k[1]) begin exp_code = 2; exp_vec = 16'h0066; e1 = 0; e2 = 1; em = 1; end
            else if (k[0]) begin exp_code = 4; exp_vec = 16'h0038; e1 = 0; e2 = 0; em = 1; end
            else begin exp_code = 0; exp_vec = 16'h0000; e1 = 1; e2 = 1; em = 1; end
            chk_act("R3 priority", exp_code, exp_vec);
            chk("R7/R8/R11 iff1", int'(iff1), e1);
            chk("R7/R8/R11 iff2", int'(iff2), e2);
            chk("R11 mode", int'(int_mode), em);
            reset_req = 1'b0; nmi_line = 1'b0; irq_line = 1'b0;
        end

        // R10 / R8: mode select sweep and per-mode IRQ acceptance
        block_reset();
        for (int s = 0; s < 4; s++) begin
            int m;
            m = (s < 2) ? 0 : s - 1;
            do_im(2'(s));
            chk("R10 mode", int'(int_mode), m);
            do_ei();
            irq_line = 1'b1;
            tick();
            mend();
            bound();
            chk_act("R8 irq", 3 + m, (m == 2) ? 16'h0000 : 16'h0038);
            chk("R8 pc_hold", int'(pc_hold), (m == 0) ? 1 : 0);
            chk("R8 iff1", int'(iff1), 0);
            chk("R8 iff2", int'(iff2), 0);
            irq_line = 1'b0;
            tick();
        end

        // R4: NMI on edge only
        block_reset();
        nmi_line = 1'b1;
        tick();
        mend();
        bound();
        chk_act("R4 first edge", 2, 16'h0066);
        mend();
        bound();
        chk_act("R4 held line", 0, 16'h0000);
        nmi_line = 1'b0;

        // R9: RETN restores IFF1 and re-arms IRQ; R5 mask
        block_reset();
        do_ei();
        tick(); nmi_line = 1'b1;
        tick(); nmi_line = 1'b0;
        mend();
        bound();
        chk_act("R7 nmi", 2, 16'h0066);
        chk("R7 iff1", int'(iff1), 0);
        chk("R7 iff2", int'(iff2), 1);
        irq_line = 1'b1;
        mend();
        bound();
        chk_act("R5 masked", 0, 16'h0000);
        do_retn();
        chk("R9 iff1", int'(iff1), 1);
        chk("R9 iff2", int'(iff2), 1);
        mend();
        bound();
        chk_act("R9 rearm", 3, 16'h0038);
        irq_line = 1'b0;

        // R6: DI cancels a sampled IRQ
        block_reset();
        do_ei();
        chk("R6 ei iff1", int'(iff1), 1);
        chk("R6 ei iff2", int'(iff2), 1);
        irq_line = 1'b1;
        mend();
        do_di();
        chk("R6 di iff1", int'(iff1), 0);
        chk("R6 di iff2", int'(iff2), 0);
        bound();
        chk_act("R6 cancel", 0, 16'h0000);
        irq_line = 1'b0;

        // R5: line dropped before the next sample
        block_reset();
        do_ei();
        irq_line = 1'b1;
        mend();
        irq_line = 1'b0;
        mend();
        bound();
        chk_act("R5 dropped", 0, 16'h0000);

        // R2: a request not yet sampled is not seen
        block_reset();
        do_ei();
        irq_line = 1'b1;
        tick();
        bound();
        chk_act("R2 unsampled", 0, 16'h0000);
        mend();
        bound();
        chk_act("R2 sampled", 3, 16'h0038);
        irq_line = 1'b0;

        // R11: level reset repeats
        block_reset();
        reset_req = 1'b1;
        mend();
        bound();
        chk_act("R11 first", 1, 16'h0000);
        bound();
        chk_act("R11 repeat", 1, 16'h0000);
        reset_req = 1'b0;
        mend();
        bound();
        chk_act("R11 released", 0, 16'h0000);

        // R12: halt held through fetches, released by a service
        block_reset();
        do_halt();
        chk("R12 halted", int'(halted), 1);
        chk("R12 pc_hold", int'(pc_hold), 1);
        bound();
        chk_act("R12 fetch", 0, 16'h0000);
        chk("R12 still halted", int'(halted), 1);
        nmi_line = 1'b1;
        tick();
        mend();
        bound();
        chk_act("R12 nmi", 2, 16'h0066);
        chk("R12 released", int'(halted), 0);
        nmi_line = 1'b0;
        tick();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule